// File: doc/BRIEF.md
# ATA Device Status and Reset Controller

This block is the device-side register and idle-state controller of a parallel ATA disk. It holds the task-file registers, a control register, and a status byte that is stored apart from the command register even though both share one offset. It decodes host byte reads and writes from the command block and the control block into actions: a primary status read, an alternate status read, a command write, a device-select write, and a control write that sets or releases software reset.

A small state machine tracks the three idle conditions: selected, selected with an interrupt pending, and not selected. It also tracks a busy state while a command runs and a soft-reset state. An accepted command raises a one-cycle start strobe towards a separate transfer engine. That engine reports completion on `cmd_done`. The block drives the host interrupt line. The interrupt is masked by the control register's interrupt-disable bit and is withdrawn when another device is selected.

Top module: `ata_dev_ctrl`

## Requirements
- R1: After hardware reset, status reads 0x40 and `irq` is low. Status bit positions: BSY bit 7, DRDY bit 6, DF bit 5, SEEK bit 4, DRQ bit 3. Task-file offsets 1 to 6 read 0. The device is selected when `dev_id` is 0 and not selected when it is 1.
- R2: A byte write at command-block offsets 1 to 6 loads that register, and a read at the same offset returns it. A write at offset 7 loads the command register, which is visible on `cmd_code`. A read at offset 7 returns the status byte and never the command.
- R3: A byte read at control-block offset 6 (alternate status) returns the same byte as the primary status read, and it leaves the interrupt state unchanged.
- R4: Wide (16-bit) accesses to the control block are ignored. A wide write changes neither the interrupt-disable bit nor the reset bit, and a wide read returns 0.
- R5: A command write in the selected idle state raises `cmd_start` for exactly the one cycle after the write, and status becomes BSY set with DRQ and DF clear. A command write in any other state gives no `cmd_start`.
- R6: `cmd_done` while busy sets status to exactly 0x50 (DRDY plus SEEK) and marks an interrupt pending. `irq` rises the cycle after, provided the interrupt-disable bit (control bit 1) is clear.
- R7: A primary status read while `irq` is high clears the pending interrupt, and `irq` is low from the next cycle.
- R8: A control write with interrupt-disable set while `irq` is high clears the pending interrupt. A completion with interrupt-disable set does not raise `irq`.
- R9: A select write (offset 6) whose bit 4 differs from `dev_id` moves a selected device to not-selected and drops `irq`, while the pending flag is kept.
- R10: From not-selected, a select write whose bit 4 equals `dev_id` re-asserts `irq` when an interrupt is pending and interrupt-disable is clear. Otherwise it returns to the selected state with `irq` low.
- R11: A byte control write with the reset bit (control bit 2) set enters soft reset and sets BSY on top of the current status. BSY holds, and command writes give no `cmd_start`, until release.
- R12: A control write with the reset bit clear while in soft reset sets status to exactly 0x40, zeroes all task-file registers, clears the pending interrupt and leaves `irq` low. The device comes out selected when `dev_id` is 0 and not selected when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_id | input | 1 | Static device number (0 or 1) compared against the select bit |
| acc_valid | input | 1 | Host access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_ctl | input | 1 | 1 = control block, 0 = command block |
| acc_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| acc_addr | input | 3 | Register offset within the block |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid in the same cycle as the read strobe |
| cmd_start | output | 1 | One-cycle strobe to the transfer engine for an accepted command |
| cmd_code | output | 8 | Current command register |
| cmd_done | input | 1 | Completion pulse from the transfer engine |
| irq | output | 1 | Host interrupt request |

## Verification
Read data is combinational, so a status or register value is due in the same cycle as the read strobe. The bench drives each access at a falling edge and samples `rd_data` 1 ns later. Every state change is due at the next rising edge. This covers `irq`, status contents, `cmd_start` and the clearing that a status read causes, so the bench checks all of them at the falling edge that follows the access. At that point `cmd_start` is still inside its single-cycle pulse. A bench model of the idle, busy and reset states predicts each value from the requirements, and directed sequences and seeded random operation mixes are checked against it.

// File: rtl/ata_dev_pkg.sv
// Package: shared constants and types for the ATA device status/reset controller.
// Assumes byte-wide task-file registers and an eight-entry command block.
package ata_dev_pkg;
    localparam int BYTE_W = 8;
    localparam int TF_ADDR_W = 3;

    // Offsets whose position the host decodes
    localparam int OFS_SELECT = 6;
    localparam int OFS_CMD    = 7;
    localparam int OFS_CTL    = 6;

    // Status byte bit masks
    localparam logic [BYTE_W-1:0] STAT_BSY  = 8'h80;
    localparam logic [BYTE_W-1:0] STAT_DRDY = 8'h40;
    localparam logic [BYTE_W-1:0] STAT_DF   = 8'h20;
    localparam logic [BYTE_W-1:0] STAT_SEEK = 8'h10;
    localparam logic [BYTE_W-1:0] STAT_DRQ  = 8'h08;

    // Control and select bit positions
    localparam int CTL_IDIS = 1;
    localparam int CTL_SRST = 2;
    localparam int SEL_BIT  = 4;

    typedef enum logic [2:0] {
        DS_SEL     = 3'd0,
        DS_SEL_IRQ = 3'd1,
        DS_DESEL   = 3'd2,
        DS_BUSY    = 3'd3,
        DS_SOFTRST = 3'd4
    } dev_state_e;

    typedef struct packed {
        logic stat_rd;
        logic alt_rd;
        logic cmd_wr;
        logic sel_wr;
        logic ctl_wr;
        logic tf_wr;
    } acc_act_t;
endpackage

// File: rtl/ata_acc_decode.sv
// Module: turns one host access into a set of action flags.
// Assumes one access per acc_valid cycle; wide accesses are never decoded.
module ata_acc_decode
    import ata_dev_pkg::*;
#(
    parameter int ADDR_W = TF_ADDR_W
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_ctl,
    input  logic              acc_wide,
    input  logic [ADDR_W-1:0] acc_addr,
    output acc_act_t          act
);
    logic byte_ok;
    logic cmd_blk_wr;

    assign byte_ok    = acc_valid && !acc_wide;
    assign cmd_blk_wr = byte_ok && acc_write && !acc_ctl && (acc_addr != '0);

    // Classify the access by block, direction and offset
    always_comb begin
        act         = '0;
        act.tf_wr   = cmd_blk_wr;
        act.sel_wr  = cmd_blk_wr && (acc_addr == ADDR_W'(OFS_SELECT));
        act.cmd_wr  = cmd_blk_wr && (acc_addr == ADDR_W'(OFS_CMD));
        act.stat_rd = byte_ok && !acc_write && !acc_ctl && (acc_addr == ADDR_W'(OFS_CMD));
        act.ctl_wr  = byte_ok && acc_write && acc_ctl && (acc_addr == ADDR_W'(OFS_CTL));
        act.alt_rd  = byte_ok && !acc_write && acc_ctl && (acc_addr == ADDR_W'(OFS_CTL));
    end
endmodule

// File: rtl/ata_taskfile.sv
// Module: task-file register bank (offset 0 is the data port and reads 0).
// Assumes a clear request and a write never target the same cycle usefully;
// the clear wins.
module ata_taskfile
    import ata_dev_pkg::*;
#(
    parameter int ADDR_W = TF_ADDR_W,
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] cmd_reg
);
    localparam int N_REG = 1 << ADDR_W;

    logic [DATA_W-1:0] regs [N_REG];

    generate
        for (genvar i = 0; i < N_REG; i++) begin : g_reg
            if (i == 0) begin : g_data_port
                assign regs[i] = '0;
            end else begin : g_store
                // Hold one register; cleared by reset or soft-reset release
                always_ff @(posedge clk) begin
                    if (!rst_n || clr) begin
                        regs[i] <= '0;
                    end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
                        regs[i] <= wr_data;
                    end
                end
            end
        end
    endgenerate

    assign rd_data = regs[rd_addr];
    assign cmd_reg = regs[N_REG-1];
endmodule

// File: rtl/ata_dev_fsm.sv
// Module: idle/busy/soft-reset state machine, status byte, pending flag,
// interrupt-disable bit and the command start strobe.
// Assumes a control write and cmd_done do not arrive in the same cycle.
module ata_dev_fsm
    import ata_dev_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_id,
    input  acc_act_t          act,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cmd_done,
    output dev_state_e        state,
    output logic [DATA_W-1:0] status,
    output logic              pend,
    output logic              idis,
    output logic              cmd_start,
    output logic              tf_clr
);
    logic       sel_match;
    dev_state_e home_state;

    assign sel_match  = (wdata[SEL_BIT] == dev_id);
    // The cleared select register has bit 4 low, so only device 0 is addressed
    assign home_state = dev_id ? DS_DESEL : DS_SEL;
    assign tf_clr     = act.ctl_wr && !wdata[CTL_SRST] && (state == DS_SOFTRST);

    // Advance the device state and keep the status byte in step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= home_state;
            status    <= STAT_DRDY;
            pend      <= 1'b0;
            idis      <= 1'b0;
            cmd_start <= 1'b0;
        end else begin
            cmd_start <= 1'b0;
            if (act.ctl_wr) begin
                idis <= wdata[CTL_IDIS];
                if (wdata[CTL_SRST]) begin
                    state  <= DS_SOFTRST;
                    status <= status | STAT_BSY;
                end else if (state == DS_SOFTRST) begin
                    state  <= home_state;
                    status <= STAT_DRDY;
                    pend   <= 1'b0;
                end else if (state == DS_SEL_IRQ && wdata[CTL_IDIS]) begin
                    state <= DS_SEL;
                    pend  <= 1'b0;
                end
            end else begin
                case (state)
                    DS_SEL: begin
                        if (act.sel_wr && !sel_match) begin
                            state <= DS_DESEL;
                        end else if (act.cmd_wr) begin
                            state     <= DS_BUSY;
                            status    <= (status | STAT_BSY) & ~(STAT_DRQ | STAT_DF);
                            cmd_start <= 1'b1;
                        end
                    end
                    DS_SEL_IRQ: begin
                        if (act.sel_wr && !sel_match) begin
                            state <= DS_DESEL;
                        end else if (act.stat_rd) begin
                            state <= DS_SEL;
                            pend  <= 1'b0;
                        end
                    end
                    DS_DESEL: begin
                        if (act.sel_wr && sel_match) begin
                            state <= (pend && !idis) ? DS_SEL_IRQ : DS_SEL;
                        end
                    end
                    DS_BUSY: begin
                        if (cmd_done) begin
                            status <= STAT_DRDY | STAT_SEEK;
                            pend   <= 1'b1;
                            state  <= idis ? DS_SEL : DS_SEL_IRQ;
                        end
                    end
                    default: begin
                        state <= state;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/ata_dev_ctrl.sv
// Module: top of the ATA device status and reset controller.
// Assumes a static dev_id and one host access per cycle; data transfer is
// handled by an external engine driven through cmd_start / cmd_done.
module ata_dev_ctrl
    import ata_dev_pkg::*;
#(
    parameter int ADDR_W = TF_ADDR_W,
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_id,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_ctl,
    input  logic              acc_wide,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              cmd_start,
    output logic [DATA_W-1:0] cmd_code,
    input  logic              cmd_done,
    output logic              irq
);
    acc_act_t          act_w;
    dev_state_e        state_w;
    logic [DATA_W-1:0] status_w;
    logic [DATA_W-1:0] tf_rd_w;
    logic              pend_w;
    logic              idis_w;
    logic              tf_clr_w;
    logic              ctl_wr_w;

    ata_acc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_ctl   (acc_ctl),
        .acc_wide  (acc_wide),
        .acc_addr  (acc_addr),
        .act       (act_w)
    );

    ata_taskfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tf_clr_w),
        .wr_en   (act_w.tf_wr),
        .wr_addr (acc_addr),
        .wr_data (acc_wdata),
        .rd_addr (acc_addr),
        .rd_data (tf_rd_w),
        .cmd_reg (cmd_code)
    );

    ata_dev_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_id    (dev_id),
        .act       (act_w),
        .wdata     (acc_wdata),
        .cmd_done  (cmd_done),
        .state     (state_w),
        .status    (status_w),
        .pend      (pend_w),
        .idis      (idis_w),
        .cmd_start (cmd_start),
        .tf_clr    (tf_clr_w)
    );

    assign ctl_wr_w = act_w.ctl_wr;
    assign irq      = (state_w == DS_SEL_IRQ);

    // Pick the read source: shared status byte, a task-file register, or 0
    always_comb begin
        if (act_w.stat_rd || act_w.alt_rd) begin
            rd_data = status_w;
        end else if (acc_valid && !acc_write && !acc_wide && !acc_ctl) begin
            rd_data = tf_rd_w;
        end else begin
            rd_data = '0;
        end
    end
endmodule

// File: rtl/ata_dev_ctrl_chk.sv
// Module: property checker for ata_dev_ctrl, attached by bind.
module ata_dev_ctrl_chk
    import ata_dev_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic        cmd_start,
    input logic        cmd_done,
    input logic        ctl_wr,
    input logic        pend,
    input logic        idis,
    input dev_state_e  state,
    input logic [7:0]  status
);
    // R5
    cmd_start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !cmd_start);

    // R5
    cmd_start_bsy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> (status[7] && !status[3] && !status[5]));

    // R6
    done_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DS_BUSY && cmd_done && !ctl_wr) |=> (status == 8'h50 && pend));

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend && !idis));

    // R11
    srst_bsy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DS_SOFTRST) |-> status[7]);

    // R12
    srst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state == DS_SOFTRST) && state != DS_SOFTRST) |-> (status == 8'h40 && !irq && !pend));
endmodule

bind ata_dev_ctrl ata_dev_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .cmd_start (cmd_start),
    .cmd_done  (cmd_done),
    .ctl_wr    (ctl_wr_w),
    .pend      (pend_w),
    .idis      (idis_w),
    .state     (state_w),
    .status    (status_w)
);

// File: tb/ata_dev_ctrl_tb.sv
module ata_dev_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dev_id = 1'b0;
    logic       acc_valid = 1'b0;
    logic       acc_write = 1'b0;
    logic       acc_ctl = 1'b0;
    logic       acc_wide = 1'b0;
    logic [2:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] rd_data;
    logic       cmd_start;
    logic [7:0] cmd_code;
    logic       cmd_done = 1'b0;
    logic       irq;

    int checks = 0;
    int fails = 0;

    // Model: 0 selected, 1 selected+irq, 2 not selected, 3 busy, 4 soft reset
    localparam int M_S = 0, M_SI = 1, M_NS = 2, M_EX = 3, M_RST = 4;
    int         m_state;
    logic [7:0] m_status;
    logic       m_pend;
    logic       m_idis;
    logic [7:0] m_tf [8];

    always #4 clk = ~clk;

    ata_dev_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .dev_id(dev_id),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_ctl(acc_ctl),
        .acc_wide(acc_wide), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .cmd_start(cmd_start), .cmd_code(cmd_code),
        .cmd_done(cmd_done), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_irq();
        return (m_state == M_SI) ? 1 : 0;
    endfunction

    task automatic model_reset();
        m_status = 8'h40;
        m_pend   = 1'b0;
        m_idis   = 1'b0;
        for (int i = 0; i < 8; i++) m_tf[i] = 8'h00;
        m_state  = (dev_id == 1'b0) ? M_S : M_NS;
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic bus(input logic ctl, input logic we, input logic wide,
                       input logic [2:0] a, input logic [7:0] d, output logic [7:0] rd);
        @(negedge clk);
        acc_valid = 1'b1; acc_ctl = ctl; acc_write = we; acc_wide = wide;
        acc_addr = a; acc_wdata = d;
        #1 rd = rd_data;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_wide = 1'b0;
    endtask

    // Command-block byte write with model update
    task automatic op_wr(input logic [2:0] a, input logic [7:0] d, input string req);
        logic [7:0] rd;
        logic       match;
        int         start_exp;
        start_exp = 0;
        match = (d[4] == dev_id);
        bus(1'b0, 1'b1, 1'b0, a, d, rd);
        if (a != 3'd0) m_tf[a] = d;
        if (m_state != M_RST && m_state != M_EX && a == 3'd6) begin
            if ((m_state == M_S || m_state == M_SI) && !match) m_state = M_NS;
            else if (m_state == M_NS && match) m_state = (m_pend && !m_idis) ? M_SI : M_S;
        end
        if (a == 3'd7) begin
            if (m_state == M_S) begin
                m_status = (m_status | 8'h80) & ~8'h28;
                m_state = M_EX;
                start_exp = 1;
            end
            check({req, " cmd_start"}, int'(cmd_start), start_exp);
            check({req, " cmd_code"}, int'(cmd_code), int'(d));
        end
        check({req, " irq"}, int'(irq), exp_irq());
    endtask

    task automatic op_rd(input logic ctl, input logic wide, input logic [2:0] a, input string req);
        logic [7:0] rd;
        logic [7:0] e;
        bus(ctl, 1'b0, wide, a, 8'h00, rd);
        if (wide) e = 8'h00;
        else if (ctl) e = (a == 3'd6) ? m_status : 8'h00;
        else if (a == 3'd7) e = m_status;
        else e = m_tf[a];
        check({req, " rd_data"}, int'(rd), int'(e));
        if (!ctl && !wide && a == 3'd7 && m_state == M_SI) begin
            m_pend = 1'b0;
            m_state = M_S;
        end
        check({req, " irq"}, int'(irq), exp_irq());
    endtask

    task automatic op_ctl(input logic [7:0] d, input logic wide, input string req);
        logic [7:0] rd;
        bus(1'b1, 1'b1, wide, 3'd6, d, rd);
        if (!wide) begin
            m_idis = d[1];
            if (d[2]) begin
                m_state = M_RST;
                m_status = m_status | 8'h80;
            end else if (m_state == M_RST) begin
                m_status = 8'h40;
                m_pend = 1'b0;
                for (int i = 0; i < 8; i++) m_tf[i] = 8'h00;
                m_state = (dev_id == 1'b0) ? M_S : M_NS;
            end else if (m_state == M_SI && d[1]) begin
                m_pend = 1'b0;
                m_state = M_S;
            end
        end
        check({req, " irq"}, int'(irq), exp_irq());
    endtask

    task automatic op_done(input string req);
        @(negedge clk);
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
        if (m_state == M_EX) begin
            m_status = 8'h50;
            m_pend = 1'b1;
            m_state = m_idis ? M_S : M_SI;
        end
        check({req, " irq"}, int'(irq), exp_irq());
    endtask

    initial begin
        #(200000 * 8);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int r;
        r = $urandom(32'h5EED_0A7A);
        hw_reset();

        // R1: reset state
        check("R1 irq", int'(irq), 0);
        check("R1 cmd_start", int'(cmd_start), 0);
        op_rd(1'b0, 1'b0, 3'd7, "R1 status");
        for (int a = 1; a < 7; a++) op_rd(1'b0, 1'b0, 3'(a), "R1 taskfile");

        // R2: task-file load and read back; command/status share offset 7
        for (int a = 1; a < 6; a++) op_wr(3'(a), 8'(8'h11 * a), "R2 write");
        for (int a = 1; a < 6; a++) op_rd(1'b0, 1'b0, 3'(a), "R2 readback");
        op_wr(3'd6, 8'hA0, "R2 select");
        op_rd(1'b0, 1'b0, 3'd6, "R2 select readback");

        // R4: wide control accesses are ignored
        op_ctl(8'h06, 1'b1, "R4 wide write");
        op_rd(1'b0, 1'b0, 3'd7, "R4 status after wide");
        op_rd(1'b1, 1'b1, 3'd6, "R4 wide read");

        // R5, R6, R3, R7: command, completion, alt read, primary read
        op_wr(3'd7, 8'h20, "R5 start");
        op_rd(1'b1, 1'b0, 3'd6, "R5 busy status");
        check("R5 pulse ends", int'(cmd_start), 0);
        op_wr(3'd7, 8'h30, "R5 ignored while busy");
        op_done("R6 completion");
        check("R6 irq raised", int'(irq), 1);
        op_rd(1'b1, 1'b0, 3'd6, "R3 alt status");
        check("R3 irq kept", int'(irq), 1);
        op_wr(3'd7, 8'hEC, "R5 ignored in irq state");
        op_rd(1'b0, 1'b0, 3'd7, "R7 primary status");
        check("R7 irq cleared", int'(irq), 0);

        // R8: interrupt-disable masks completion
        op_ctl(8'h02, 1'b0, "R8 disable");
        op_wr(3'd7, 8'h20, "R8 start");
        op_done("R8 masked completion");
        check("R8 no irq", int'(irq), 0);
        op_ctl(8'h00, 1'b0, "R8 enable");
        op_wr(3'd6, 8'hB0, "R9 deselect");
        op_wr(3'd6, 8'hA0, "R10 reselect pending");
        check("R10 irq back", int'(irq), 1);
        op_ctl(8'h02, 1'b0, "R8 disable clears");
        check("R8 irq cleared", int'(irq), 0);
        op_ctl(8'h00, 1'b0, "R8 enable again");

        // R9, R10: deselect drops irq, reselect restores it
        op_wr(3'd7, 8'h20, "R9 start");
        op_done("R9 completion");
        op_wr(3'd6, 8'hB0, "R9 deselect");
        check("R9 irq dropped", int'(irq), 0);
        op_wr(3'd7, 8'h20, "R5 ignored deselected");
        op_wr(3'd6, 8'hA0, "R10 reselect");
        check("R10 irq reasserted", int'(irq), 1);
        op_rd(1'b0, 1'b0, 3'd7, "R7 clear");
        op_wr(3'd6, 8'hB0, "R9 deselect idle");
        op_wr(3'd6, 8'hA0, "R10 reselect no pending");
        check("R10 no irq", int'(irq), 0);

        // R11, R12: soft reset with a pending interrupt
        op_wr(3'd7, 8'h20, "R11 start");
        op_done("R11 completion");
        op_ctl(8'h04, 1'b0, "R11 set reset");
        check("R11 irq low", int'(irq), 0);
        op_rd(1'b1, 1'b0, 3'd6, "R11 bsy status");
        op_wr(3'd7, 8'h20, "R11 cmd ignored");
        op_wr(3'd3, 8'h5A, "R12 pre-write");
        op_ctl(8'h00, 1'b0, "R12 release");
        op_rd(1'b0, 1'b0, 3'd7, "R12 status");
        for (int a = 1; a < 7; a++) op_rd(1'b0, 1'b0, 3'(a), "R12 taskfile");
        op_wr(3'd6, 8'hB0, "R12 deselect");
        op_wr(3'd6, 8'hA0, "R12 reselect");
        check("R12 pending cleared", int'(irq), 0);

        // R1, R12: device 1 starts not selected
        dev_id = 1'b1;
        hw_reset();
        op_wr(3'd7, 8'h20, "R1 dev1 ignored");
        op_wr(3'd6, 8'hB0, "R10 dev1 select");
        op_wr(3'd7, 8'h20, "R5 dev1 start");
        op_done("R6 dev1 completion");
        op_ctl(8'h04, 1'b0, "R11 dev1 reset");
        op_ctl(8'h00, 1'b0, "R12 dev1 release");
        op_wr(3'd7, 8'h20, "R12 dev1 not selected");

        // Seeded random mix against the model
        dev_id = 1'b0;
        hw_reset();
        for (int n = 0; n < 400; n++) begin
            int op;
            op = int'($urandom_range(0, 8));
            case (op)
                0: op_wr(3'd6, 8'($urandom_range(0, 255)), "R9/R10 rand select");
                1: op_wr(3'd7, 8'($urandom_range(0, 255)), "R5 rand command");
                2: op_done("R6 rand completion");
                3: op_rd(1'b0, 1'b0, 3'd7, "R7 rand primary");
                4: op_rd(1'b1, 1'b0, 3'd6, "R3 rand alt");
                5: op_rd(1'b0, 1'b0, 3'($urandom_range(0, 6)), "R2 rand read");
                6: op_wr(3'($urandom_range(1, 5)), 8'($urandom_range(0, 255)), "R2 rand write");
                7: op_ctl({6'd0, 1'($urandom_range(0, 1)), 1'b0}, 1'b0, "R8 rand disable");
                default: op_rd(1'b1, 1'b1, 3'd6, "R4 rand wide");
            endcase
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule